// File: doc/BRIEF.md
# Control-Register Bus Master with Four-Phase Strobe Handshakes

This block turns a single read or write request into the ordered sequence of strobe phases that a PHY's internal control-register port expects. A requester presents a 16-bit register address, a direction and, for a write, 16 bits of data on a valid/ready command port. The engine then steps through the phases of that transaction. Each phase drives one strobe and completes a full four-phase handshake against the PHY's single acknowledge line before the next phase begins.

A phase proceeds in three steps. The word that the phase carries is placed on the shared data-in bus for one cycle with every strobe low. The phase's strobe is then raised and held until acknowledge is seen high. The strobe is dropped and the engine waits for acknowledge to fall. Every transaction opens with an address phase. A write then runs a capture-data phase and a write-strobe phase. A read runs a read-strobe phase, and the PHY's output word is sampled while acknowledge is still high.

Each wait for acknowledge is bounded by a cycle limit set on an input. If the limit runs out, the transaction is abandoned and reported as failed. When a transaction ends, the engine gives a one-cycle completion pulse.

Top module: `crbus_master`

## Requirements
- R1: `cmd_ready` is 1 exactly when the engine is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. A command presented while `cmd_ready` is 0 is ignored and never reaches the PHY.
- R2: Every transaction starts with an address phase. `bus_din` carries `cmd_addr` from one cycle before `cap_addr` rises until after it falls.
- R3: In a clock edge where a strobe is high and `bus_ack` is high, the strobe goes low on that edge. The next strobe rises only after `bus_ack` has been seen low, with at least one cycle of all strobes low in between.
- R4: A read runs the address phase and then a read phase on `rd_stb`. The word on `bus_dout` is captured while `bus_ack` is high during the read phase.
- R5: A write runs three phases in this order: address on `cap_addr`, data on `cap_data` with `cmd_wdata` on `bus_din`, then `wr_stb`.
- R6: At most one of `cap_addr`, `cap_data`, `rd_stb` and `wr_stb` is high in any cycle.
- R7: `done` is a one-cycle pulse at the end of every transaction. `rd_data` changes only in a `done` cycle that ends a successful read, and otherwise keeps its value.
- R8: With `timeout_cycles` = L and L non-zero, an acknowledge that is not seen within L cycles of a wait aborts the transaction. All strobes go low, `done` and `err` pulse together for one cycle, and the engine returns to idle with `rd_data` unchanged. An acknowledge that arrives on the L-th cycle still succeeds.
- R9: `timeout_cycles` = 0 disables the timeout, so waits of any length succeed.
- R10: A synchronous active-high `rst` leaves the engine idle with `cmd_ready` = 1, all strobes low, `done` = 0, `err` = 0 and `rd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Register address |
| cmd_wdata | input | DATA_W | Write data |
| timeout_cycles | input | TMO_W | Acknowledge wait limit, 0 = no limit |
| rd_data | output | DATA_W | Data of the last successful read |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | One-cycle pulse with done on a timeout abort |
| bus_din | output | DATA_W | Shared address/data bus to the PHY |
| cap_addr | output | 1 | Address capture strobe |
| cap_data | output | 1 | Data capture strobe |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| bus_ack | input | 1 | Acknowledge from the PHY |
| bus_dout | input | DATA_W | Read word from the PHY |

## Verification
A PHY model with a programmable acknowledge delay logs the order of strobe phases and the words it latches, so that each vector checks the phase sequence. A design that skipped the data phase, or merged it with the write strobe, would produce the wrong log. The timeout is tested on both sides of its limit: a delay that lands on the last allowed cycle must succeed, and one cycle more must abort. An off-by-one counter fails one of the two. A PHY that never answers must lead to an abort that leaves `rd_data` untouched, and a limit of zero must tolerate long delays. A command held on the port during a busy transaction must never reach the PHY; a design that accepted it would write a register that a later read expects to find zero.

// File: rtl/crbus_pkg.sv
package crbus_pkg;
  localparam int NUM_STB = 4;

  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,
    PH_DATA  = 2'd1,
    PH_WRITE = 2'd2,
    PH_READ  = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_ASSERT  = 2'd2,
    ST_RELEASE = 2'd3
  } state_e;
endpackage

// File: rtl/crbus_wait_timer.sv
module crbus_wait_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [TMO_W-1:0] limit,
  output logic             expired
);
  localparam logic [TMO_W-1:0] CNT_MAX = {TMO_W{1'b1}};

  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run || restart) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_MAX) begin
      cnt_q <= cnt_q + TMO_W'(1);
    end
  end

  // cnt_q holds the number of completed wait cycles; the wait fails on cycle L
  assign expired = run && (limit != '0) && (cnt_q == limit - TMO_W'(1));
endmodule

// File: rtl/crbus_strobe_dec.sv
module crbus_strobe_dec
  import crbus_pkg::*;
(
  input  logic               on,
  input  phase_e             phase,
  output logic [NUM_STB-1:0] stb
);
  for (genvar i = 0; i < NUM_STB; i++) begin : g_stb
    assign stb[i] = on && (phase == phase_e'(i));
  end
endmodule

// File: rtl/crbus_seq.sv
module crbus_seq
  import crbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              ack,
  input  logic [DATA_W-1:0] dout,
  input  logic              expired,
  output logic              ready,
  output logic              stb_on,
  output phase_e            phase,
  output logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              err,
  output logic              wait_run,
  output logic              wait_restart
);
  state_e            state_q;
  logic              is_wr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] cap_q;

  assign wait_run     = (state_q == ST_ASSERT) || (state_q == ST_RELEASE);
  assign wait_restart = (state_q == ST_ASSERT) && ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      phase   <= PH_ADDR;
      is_wr_q <= 1'b0;
      wdata_q <= '0;
      cap_q   <= '0;
      din     <= '0;
      rd_data <= '0;
      stb_on  <= 1'b0;
      ready   <= 1'b1;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            is_wr_q <= cmd_write;
            wdata_q <= cmd_wdata;
            din     <= DATA_W'(cmd_addr);
            phase   <= PH_ADDR;
            ready   <= 1'b0;
            state_q <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          stb_on  <= 1'b1;
          state_q <= ST_ASSERT;
        end
        ST_ASSERT: begin
          if (ack) begin
            stb_on <= 1'b0;
            if (phase == PH_READ) cap_q <= dout;
            state_q <= ST_RELEASE;
          end else if (expired) begin
            stb_on  <= 1'b0;
            done    <= 1'b1;
            err     <= 1'b1;
            ready   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_RELEASE: begin
          if (!ack) begin
            unique case (phase)
              PH_ADDR: begin
                if (is_wr_q) begin
                  phase <= PH_DATA;
                  din   <= wdata_q;
                end else begin
                  phase <= PH_READ;
                end
                state_q <= ST_SETUP;
              end
              PH_DATA: begin
                phase   <= PH_WRITE;
                state_q <= ST_SETUP;
              end
              PH_READ: begin
                rd_data <= cap_q;
                done    <= 1'b1;
                ready   <= 1'b1;
                state_q <= ST_IDLE;
              end
              default: begin
                done    <= 1'b1;
                ready   <= 1'b1;
                state_q <= ST_IDLE;
              end
            endcase
          end else if (expired) begin
            done    <= 1'b1;
            err     <= 1'b1;
            ready   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/crbus_master.sv
module crbus_master
  import crbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int TMO_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic [TMO_W-1:0]  timeout_cycles,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] bus_din,
  output logic              cap_addr,
  output logic              cap_data,
  output logic              rd_stb,
  output logic              wr_stb,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_dout
);
  logic               stb_on;
  phase_e             phase;
  logic               expired;
  logic               wait_run;
  logic               wait_restart;
  logic [NUM_STB-1:0] stb;

  crbus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid    (cmd_valid),
    .cmd_write    (cmd_write),
    .cmd_addr     (cmd_addr),
    .cmd_wdata    (cmd_wdata),
    .ack          (bus_ack),
    .dout         (bus_dout),
    .expired      (expired),
    .ready        (cmd_ready),
    .stb_on       (stb_on),
    .phase        (phase),
    .din          (bus_din),
    .rd_data      (rd_data),
    .done         (done),
    .err          (err),
    .wait_run     (wait_run),
    .wait_restart (wait_restart)
  );

  crbus_wait_timer #(.TMO_W(TMO_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (wait_run),
    .restart (wait_restart),
    .limit   (timeout_cycles),
    .expired (expired)
  );

  crbus_strobe_dec u_dec (
    .on    (stb_on),
    .phase (phase),
    .stb   (stb)
  );

  assign cap_addr = stb[PH_ADDR];
  assign cap_data = stb[PH_DATA];
  assign wr_stb   = stb[PH_WRITE];
  assign rd_stb   = stb[PH_READ];
endmodule

// File: rtl/crbus_checker.sv
module crbus_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_ready,
  input logic              cap_addr,
  input logic              cap_data,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic              bus_ack,
  input logic [DATA_W-1:0] bus_din,
  input logic              done,
  input logic              err,
  input logic [DATA_W-1:0] rd_data
);
  logic [3:0] stbs;
  logic       any_stb;
  assign stbs    = {cap_addr, cap_data, rd_stb, wr_stb};
  assign any_stb = |stbs;

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $countones(stbs) <= 1);

  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (rst)
    any_stb |-> !cmd_ready);

  assert_drop_on_ack_R3: assert property (@(posedge clk) disable iff (rst)
    (any_stb && bus_ack) |=> !any_stb);

  assert_din_held_R2: assert property (@(posedge clk) disable iff (rst)
    (any_stb && $past(any_stb)) |-> $stable(bus_din));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(rd_data));

  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && !any_stb));
endmodule

bind crbus_master crbus_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_ready (cmd_ready),
  .cap_addr  (cap_addr),
  .cap_data  (cap_data),
  .rd_stb    (rd_stb),
  .wr_stb    (wr_stb),
  .bus_ack   (bus_ack),
  .bus_din   (bus_din),
  .done      (done),
  .err       (err),
  .rd_data   (rd_data)
);

// File: tb/tb_crbus_master.sv
module tb_crbus_master;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [15:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic [15:0] timeout_cycles = 16'd10;
  logic [15:0] rd_data;
  logic        done, err;
  logic [15:0] bus_din;
  logic        cap_addr, cap_data, rd_stb, wr_stb;
  logic        bus_ack = 1'b0;
  logic [15:0] bus_dout = '0;

  always #4 clk = ~clk;

  crbus_master dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .timeout_cycles(timeout_cycles), .rd_data(rd_data), .done(done), .err(err),
    .bus_din(bus_din), .cap_addr(cap_addr), .cap_data(cap_data),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .bus_ack(bus_ack), .bus_dout(bus_dout)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // PHY model
  logic [15:0] mem [16];
  logic [15:0] lat_addr, lat_data;
  int          dly = 0;
  bit          hang = 0;
  int          rcnt = 0;
  int          overlaps = 0;
  logic [1:0]  plog [8];
  int          plog_n = 0;

  task automatic push_log(input logic [1:0] code);
    if (plog_n < 8) begin
      plog[plog_n] = code;
      plog_n++;
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    lat_addr = '0;
    lat_data = '0;
    forever begin
      logic [3:0] s;
      @(posedge clk);
      s = {cap_addr, cap_data, wr_stb, rd_stb};
      if ($countones(s) > 1) overlaps++;
      if (rst) begin
        bus_ack <= 1'b0;
        rcnt = 0;
      end else if (hang) begin
        rcnt = 0;
      end else if ((|s) != bus_ack) begin
        if (rcnt >= dly) begin
          rcnt = 0;
          if (s[3]) begin lat_addr = bus_din; push_log(2'd0); end
          if (s[2]) begin lat_data = bus_din; push_log(2'd1); end
          if (s[1]) begin mem[lat_addr[3:0]] = lat_data; push_log(2'd2); end
          if (s[0]) begin bus_dout <= mem[lat_addr[3:0]]; push_log(2'd3); end
          bus_ack <= |s;
        end else begin
          rcnt++;
        end
      end else begin
        rcnt = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  logic [15:0] last_rd;
  logic        last_err;

  // issue one command and wait for its done pulse
  task automatic run_cmd(input bit wr, input logic [15:0] a, input logic [15:0] d);
    int guard;
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    plog_n = 0;
    cmd_valid = 1'b1;
    cmd_write = wr;
    cmd_addr = a;
    cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    guard = 0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    last_rd = rd_data;
    last_err = err;
    chk(done, "R7", "done seen", {31'd0, done}, 32'd1);
    @(negedge clk);
    chk(!done, "R7", "done one cycle", {31'd0, done}, 32'd0);
    chk(cmd_ready, "R1", "ready after done", {31'd0, cmd_ready}, 32'd1);
  endtask

  // {write, addr, data, ack delay}; for reads, data is the expected word
  localparam int NV = 9;
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 16'h1023, 16'h1234, 4'd0},
    {1'b1, 16'h0045, 16'hABCD, 4'd1},
    {1'b0, 16'h1023, 16'h1234, 4'd0},
    {1'b0, 16'h0045, 16'hABCD, 4'd2},
    {1'b1, 16'h1023, 16'hFFFF, 4'd3},
    {1'b0, 16'h1023, 16'hFFFF, 4'd1},
    {1'b0, 16'h200F, 16'h0000, 4'd0},
    {1'b1, 16'h002F, 16'h8001, 4'd2},
    {1'b0, 16'h002F, 16'h8001, 4'd0}
  };

  initial begin
    logic [15:0] prev_rd;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    chk(cmd_ready == 1'b1, "R10", "ready in reset", {31'd0, cmd_ready}, 32'd1);
    chk({cap_addr, cap_data, rd_stb, wr_stb} == 4'd0, "R10", "strobes in reset",
        {28'd0, cap_addr, cap_data, rd_stb, wr_stb}, 32'd0);
    chk(!done && !err, "R10", "done/err in reset", {30'd0, done, err}, 32'd0);
    chk(rd_data == 16'd0, "R10", "rd_data in reset", {16'd0, rd_data}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R10", "idle after reset", {31'd0, cmd_ready}, 32'd1);

    // vector table
    timeout_cycles = 16'd10;
    prev_rd = rd_data;
    for (int v = 0; v < NV; v++) begin
      logic        wr;
      logic [15:0] a, d;
      wr = VEC[v][36];
      a = VEC[v][35:20];
      d = VEC[v][19:4];
      dly = int'(VEC[v][3:0]);
      run_cmd(wr, a, d);
      chk(!last_err, "R8", "no error", {31'd0, last_err}, 32'd0);
      chk(lat_addr == a, "R2", "address latched", {16'd0, lat_addr}, {16'd0, a});
      if (wr) begin
        chk(plog_n == 3 && plog[0] == 2'd0 && plog[1] == 2'd1 && plog[2] == 2'd2,
            "R5", "write phase order", {plog_n[7:0], 18'd0, plog[0], plog[1], plog[2]},
            {8'd3, 18'd0, 2'd0, 2'd1, 2'd2});
        chk(lat_data == d, "R5", "write data latched", {16'd0, lat_data}, {16'd0, d});
        chk(last_rd == prev_rd, "R7", "rd_data held on write", {16'd0, last_rd},
            {16'd0, prev_rd});
      end else begin
        chk(plog_n == 2 && plog[0] == 2'd0 && plog[1] == 2'd3,
            "R4", "read phase order", {plog_n[7:0], 20'd0, plog[0], plog[1]},
            {8'd2, 20'd0, 2'd0, 2'd3});
        chk(last_rd == d, "R4", "read data", {16'd0, last_rd}, {16'd0, d});
        prev_rd = d;
      end
    end

    // R1: command held while busy is ignored
    dly = 2;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 16'h0007; cmd_wdata = 16'h5555;
    plog_n = 0;
    @(negedge clk);
    cmd_addr = 16'h0008; cmd_wdata = 16'h6666;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!cmd_ready, "R1", "not ready while busy", {31'd0, cmd_ready}, 32'd0);
    end
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    dly = 0;
    run_cmd(1'b0, 16'h0008, 16'h0);
    chk(last_rd == 16'h0000, "R1", "busy command ignored", {16'd0, last_rd}, 32'd0);
    run_cmd(1'b0, 16'h0007, 16'h0);
    chk(last_rd == 16'h5555, "R1", "first command done", {16'd0, last_rd}, 32'h5555);

    // R8 boundary: limit 4, ack seen on the 4th wait cycle -> success
    timeout_cycles = 16'd4;
    dly = 2;
    run_cmd(1'b1, 16'h000A, 16'h0A0A);
    chk(!last_err, "R8", "ack on last allowed cycle", {31'd0, last_err}, 32'd0);
    // one cycle more -> abort
    dly = 3;
    prev_rd = rd_data;
    run_cmd(1'b0, 16'h000A, 16'h0);
    chk(last_err, "R8", "abort one cycle late", {31'd0, last_err}, 32'd1);
    chk({cap_addr, cap_data, rd_stb, wr_stb} == 4'd0, "R8", "strobes low after abort",
        {28'd0, cap_addr, cap_data, rd_stb, wr_stb}, 32'd0);
    chk(last_rd == prev_rd, "R8", "rd_data kept on abort", {16'd0, last_rd},
        {16'd0, prev_rd});
    repeat (20) @(negedge clk);

    // R8: PHY never answers
    hang = 1;
    timeout_cycles = 16'd6;
    run_cmd(1'b0, 16'h000A, 16'h0);
    chk(last_err, "R8", "abort on silent PHY", {31'd0, last_err}, 32'd1);
    chk(last_rd == prev_rd, "R8", "rd_data kept on silent PHY", {16'd0, last_rd},
        {16'd0, prev_rd});
    hang = 0;
    repeat (5) @(negedge clk);

    // R9: limit zero, long delay
    timeout_cycles = 16'd0;
    dly = 12;
    run_cmd(1'b1, 16'h000B, 16'hBEEF);
    chk(!last_err, "R9", "no timeout when disabled", {31'd0, last_err}, 32'd0);
    run_cmd(1'b0, 16'h000B, 16'h0);
    chk(!last_err && last_rd == 16'hBEEF, "R9", "long read", {15'd0, last_err, last_rd},
        {16'd0, 16'hBEEF});
    dly = 0;
    timeout_cycles = 16'd10;
    run_cmd(1'b0, 16'h000A, 16'h0);
    chk(last_rd == 16'h0A0A, "R8", "recovery after abort", {16'd0, last_rd}, 32'h0A0A);

    chk(overlaps == 0, "R6", "single strobe", overlaps, 32'd0);
    report();
  end
endmodule